// File: doc/BRIEF.md
# Indexed-Register I2C Slave

This block is a two-wire serial slave that gives a host access to a small peripheral through one selector byte. Every write message names an element with the first byte after the device address, and any later bytes in that message go to that element. A read message takes no selector of its own. It returns bytes from whatever element the most recent write selected. A read may follow a write directly through a repeated START, which lets the host set the selector and read it back in one transfer.

Control, interrupt-enable and interrupt-flag registers are reached directly by index. A small RAM is reached only indirectly: the host loads a pointer register and then moves data through a data window register. The pointer steps by one for each byte that passes through the window. Internal event inputs set sticky flags, and an active-low interrupt output tells the host when an enabled flag is pending, so the host does not have to poll.

Top module: `idx_i2c_slave`

## Requirements
- R1: After reset `int_n` is 1, `sda_oe` is 0, `ctrl_o` is 0, the selector is 0, and the flag, enable and pointer registers are 0.
- R2: The device answers only the 7-bit address DEV_ADDR (default 0x2A), with the R/W bit as the address byte's LSB (0 = write). For any other address it does not acknowledge, drives nothing, and the message changes no state.
- R3: In a write message the byte after the address is acknowledged and becomes the selector. Every later byte is acknowledged and written to the selected element. A direct register selector does not advance, so the last byte written wins.
- R4: A read message returns bytes from the most recently written selector. This holds both in a separate message and after a repeated START. Repeated reads of a direct register return the same value.
- R5: During a read the slave shifts out MSB first and stops driving SDA after the master's not-acknowledge, which ends the read.
- R6: The index map is: 0x00 event flags, 0x01 interrupt enables, 0x02 control (driven on `ctrl_o`), 0x03 RAM pointer, 0x04 RAM data window. Every other index reads 0 and ignores writes.
- R7: Each byte written to index 0x04 goes to RAM[pointer]. Each byte fetched from index 0x04 for transmission is read from RAM[pointer]. After each such byte the pointer advances by one, modulo MEM_WORDS.
- R8: Bits that cannot be stored are discarded on write and read back as 0. These are the flag and enable bits above NUM_EVT-1 and the pointer bits above log2(MEM_WORDS)-1.
- R9: A high `evt_i[k]` sets flag bit k, and the bit stays set. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R10: `int_n` is 0 exactly while some flag bit and its enable bit (1 = enabled) are both set.
- R11: A START or STOP on the bus aborts any byte in progress. A partial data byte cut off this way writes nothing. After a START the slave expects an address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | When 1, pulls the data line low |
| evt_i | input | NUM_EVT | Event inputs that set the interrupt flags |
| int_n | output | 1 | Active-low interrupt request |
| ctrl_o | output | 8 | Contents of the control register |

## Verification
The assertions assume the bus is slow compared with `clk`: each SCL level lasts well over three clock cycles, and SDA changes only while SCL is low except for START and STOP. Under those conditions every edge reaches the synchronizer as a clean transition. The master model in the bench keeps every quarter bit period at ten clocks and places all data changes in the SCL-low phase. Events are single-cycle pulses applied while the bus is idle, so an event never lands on the same edge as a change to the enables.

// File: rtl/idx_i2c_slave.sv
module idx_i2c_slave #(
  parameter logic [6:0] DEV_ADDR  = 7'h2A,
  parameter int         MEM_WORDS = 16,
  parameter int         NUM_EVT   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               int_n,
  output logic [7:0]         ctrl_o
);
  localparam int PW = $clog2(MEM_WORDS);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK, S_LOAD} st_t;

  logic [2:0] scl_sy, sda_sy;
  st_t        st;
  logic [1:0] kind_q;
  logic       rw_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q, tx_q, idx_q, ctrl_q, rd_data;
  logic [NUM_EVT-1:0] flag_q, en_q, clr;
  logic [PW-1:0] ptr_q;
  logic [7:0] mem_q [MEM_WORDS];

  wire scl_rise  = scl_sy[1] & ~scl_sy[2];
  wire scl_fall  = ~scl_sy[1] & scl_sy[2];
  wire start_det = scl_sy[1] & scl_sy[2] & sda_sy[2] & ~sda_sy[1];
  wire stop_det  = scl_sy[1] & scl_sy[2] & ~sda_sy[2] & sda_sy[1];
  wire byte_done = (st == S_RX) && scl_fall && (bit_q == 4'd8);
  wire wr_stb    = byte_done && (kind_q == 2'd2);
  wire rd_stb    = scl_fall && (((st == S_ACK) && rw_q) || (st == S_LOAD));
  wire win_step  = (wr_stb || rd_stb) && (idx_q == 8'h04);

  assign sda_oe = (st == S_ACK) || ((st == S_TX) && !tx_q[7]);
  assign int_n  = ~|(flag_q & en_q);
  assign ctrl_o = ctrl_q;
  assign clr    = (wr_stb && idx_q == 8'h00) ? sh_q[NUM_EVT-1:0] : '0;

  always_comb begin
    case (idx_q)
      8'h00:   rd_data = 8'(flag_q);
      8'h01:   rd_data = 8'(en_q);
      8'h02:   rd_data = ctrl_q;
      8'h03:   rd_data = 8'(ptr_q);
      8'h04:   rd_data = mem_q[ptr_q];
      default: rd_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind_q <= '0; rw_q <= 1'b0; bit_q <= '0;
      sh_q <= '0; tx_q <= 8'hFF; idx_q <= '0;
    end else if (start_det) begin
      st <= S_RX; bit_q <= '0; kind_q <= '0;
    end else if (stop_det) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: ;
        S_RX:
          if (scl_rise && bit_q != 4'd8) begin
            sh_q  <= {sh_q[6:0], sda_sy[1]};
            bit_q <= bit_q + 4'd1;
          end else if (byte_done) begin
            if (kind_q == 2'd0) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                rw_q <= sh_q[0];
                st   <= S_ACK;
              end else st <= S_IDLE;
            end else begin
              st <= S_ACK;
              if (kind_q == 2'd1) idx_q <= sh_q;
            end
          end
        S_ACK:
          if (scl_fall) begin
            bit_q <= '0;
            if (rw_q) begin
              tx_q <= rd_data;
              st   <= S_TX;
            end else begin
              st <= S_RX;
              if (kind_q != 2'd2) kind_q <= kind_q + 2'd1;
            end
          end
        S_TX:
          if (scl_fall) begin
            tx_q  <= {tx_q[6:0], 1'b1};
            bit_q <= bit_q + 4'd1;
            if (bit_q == 4'd7) st <= S_MACK;
          end
        S_MACK:
          if (scl_rise) st <= sda_sy[1] ? S_IDLE : S_LOAD;
        S_LOAD:
          if (scl_fall) begin
            tx_q  <= rd_data;
            bit_q <= '0;
            st    <= S_TX;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0; en_q <= '0; ctrl_q <= '0; ptr_q <= '0;
    end else begin
      flag_q <= (flag_q & ~clr) | evt_i;
      if (wr_stb && idx_q == 8'h01) en_q   <= sh_q[NUM_EVT-1:0];
      if (wr_stb && idx_q == 8'h02) ctrl_q <= sh_q;
      if (wr_stb && idx_q == 8'h03) ptr_q  <= sh_q[PW-1:0];
      else if (win_step)            ptr_q  <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_stb && idx_q == 8'h04) mem_q[ptr_q] <= sh_q;
  end
endmodule

module idx_i2c_slave_chk #(
  parameter int NUM_EVT = 4,
  parameter int PW      = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sda_oe,
  input logic               int_n,
  input logic [7:0]         ctrl_o,
  input logic [NUM_EVT-1:0] evt_i,
  input logic [NUM_EVT-1:0] en_q,
  input logic [NUM_EVT-1:0] flag_q,
  input logic [PW-1:0]      ptr_q,
  input logic [7:0]         idx_q,
  input logic               wr_stb,
  input logic               stop_det
);
  wire ptr_wr  = wr_stb && (idx_q == 8'h03);
  wire ctrl_wr = wr_stb && (idx_q == 8'h02);
  wire flg_wr  = wr_stb && (idx_q == 8'h00);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (int_n && !sda_oe && ctrl_o == 8'h00));

  assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctrl_wr) |-> $stable(ctrl_o));

  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ptr_wr) |-> (ptr_q == $past(ptr_q) || ptr_q == $past(ptr_q) + 1'b1));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flg_wr) |-> ((flag_q & $past(flag_q)) == $past(flag_q)));

  assert_irq_follows_evt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & en_q)) |=> (!int_n || !$stable(en_q)));
endmodule

bind idx_i2c_slave idx_i2c_slave_chk #(.NUM_EVT(NUM_EVT), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .int_n(int_n), .ctrl_o(ctrl_o),
  .evt_i(evt_i), .en_q(en_q), .flag_q(flag_q), .ptr_q(ptr_q), .idx_q(idx_q),
  .wr_stb(wr_stb), .stop_det(stop_det)
);

// File: tb/idx_i2c_slave_test.sv
module idx_i2c_slave_test;
  localparam logic [6:0] ADDR = 7'h2A;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [3:0] evt = '0;
  logic sda_oe, int_n;
  logic [7:0] ctrl_o;
  wire sda_bus = sda_m & ~sda_oe;
  int checks = 0, errs = 0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always #2 clk = ~clk;

  idx_i2c_slave uut (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .evt_i(evt), .int_n(int_n), .ctrl_o(ctrl_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask
  task automatic bstart(); sda_m = 1; qw(); scl_m = 1; qw(); sda_m = 0; qw(); scl_m = 0; qw(); endtask
  task automatic bstop(); sda_m = 0; qw(); scl_m = 1; qw(); sda_m = 1; qw(); endtask
  task automatic bit_out(input logic b); sda_m = b; qw(); scl_m = 1; qw(); qw(); scl_m = 0; qw(); endtask
  task automatic bit_in(output logic b); sda_m = 1; qw(); scl_m = 1; qw(); b = sda_bus; qw(); scl_m = 0; qw(); endtask

  task automatic byte_out(input logic [7:0] d, output logic ack);
    logic nak;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(nak);
    ack = !nak;
  endtask

  task automatic byte_in(output logic [7:0] d, input logic last);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(last);
  endtask

  task automatic wr_msg(input logic [7:0] idx, input int n);
    logic ack;
    bstart();
    byte_out({ADDR, 1'b0}, ack); chk("R2 address ack", ack, 1);
    byte_out(idx, ack);          chk("R3 index ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      byte_out(wbuf[i], ack);    chk("R3 data ack", ack, 1);
    end
    bstop();
  endtask

  task automatic rd_msg(input logic rep, input logic [7:0] idx, input int n);
    logic ack;
    bstart();
    if (rep) begin
      byte_out({ADDR, 1'b0}, ack);
      byte_out(idx, ack);
      bstart();
    end
    byte_out({ADDR, 1'b1}, ack); chk("R4 read address ack", ack, 1);
    for (int i = 0; i < n; i++) byte_in(rbuf[i], i == n - 1);
    chk("R5 sda released after nack", sda_oe, 0);
    bstop();
  endtask

  task automatic t_reset();
    chk("R1 int_n", int_n, 1);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 ctrl_o", ctrl_o, 0);
    rd_msg(0, 0, 1);
    chk("R1 flags at default index", rbuf[0], 0);
  endtask

  task automatic t_ctrl();
    wbuf[0] = 8'h5A; wbuf[1] = 8'hA5;
    wr_msg(8'h02, 2);
    chk("R3 last byte wins", ctrl_o, 8'hA5);
    rd_msg(1, 8'h02, 2);
    chk("R4 combined read b0", rbuf[0], 8'hA5);
    chk("R4 combined read b1", rbuf[1], 8'hA5);
    rd_msg(0, 0, 1);
    chk("R4 read reuses index", rbuf[0], 8'hA5);
    rd_msg(1, 8'h03, 1);
    chk("R6 pointer untouched", rbuf[0], 8'h00);
  endtask

  task automatic t_foreign();
    logic ack;
    bstart();
    byte_out({7'h2B, 1'b0}, ack); chk("R2 foreign nack", ack, 0);
    byte_out(8'h02, ack);         chk("R2 no ack after foreign", ack, 0);
    byte_out(8'h00, ack);
    bstop();
    chk("R2 ctrl unchanged", ctrl_o, 8'hA5);
  endtask

  task automatic t_mem();
    wbuf[0] = 8'h0E; wr_msg(8'h03, 1);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_msg(8'h04, 3);
    rd_msg(1, 8'h03, 1);
    chk("R7 pointer wrapped after writes", rbuf[0], 8'h01);
    wbuf[0] = 8'h0E; wr_msg(8'h03, 1);
    rd_msg(1, 8'h04, 3);
    chk("R7 ram byte 0", rbuf[0], 8'h11);
    chk("R7 ram byte 1", rbuf[1], 8'h22);
    chk("R7 ram byte 2 wrapped", rbuf[2], 8'h33);
    rd_msg(1, 8'h03, 1);
    chk("R7 pointer after fetches", rbuf[0], 8'h01);
  endtask

  task automatic t_ro();
    wbuf[0] = 8'hF3; wr_msg(8'h03, 1);
    rd_msg(1, 8'h03, 1);
    chk("R8 pointer high bits", rbuf[0], 8'h03);
    wbuf[0] = 8'hFF; wr_msg(8'h01, 1);
    rd_msg(1, 8'h01, 1);
    chk("R8 enable high bits", rbuf[0], 8'h0F);
    wbuf[0] = 8'h00; wr_msg(8'h01, 1);
    wbuf[0] = 8'h55; wr_msg(8'h07, 1);
    rd_msg(1, 8'h07, 1);
    chk("R6 unused index reads 0", rbuf[0], 8'h00);
    chk("R6 unused write no effect", ctrl_o, 8'hA5);
  endtask

  task automatic t_irq();
    @(negedge clk); evt = 4'b0010; @(negedge clk); evt = '0;
    qw();
    chk("R10 masked flag keeps int high", int_n, 1);
    rd_msg(1, 8'h00, 1);
    chk("R9 flag latched", rbuf[0], 8'h02);
    wbuf[0] = 8'h02; wr_msg(8'h01, 1);
    chk("R10 enabled flag asserts int", int_n, 0);
    wbuf[0] = 8'h01; wr_msg(8'h00, 1);
    chk("R9 clear other bit no effect", int_n, 0);
    rd_msg(1, 8'h00, 1);
    chk("R9 flag still set", rbuf[0], 8'h02);
    wbuf[0] = 8'h02; wr_msg(8'h00, 1);
    chk("R10 int released", int_n, 1);
    rd_msg(0, 0, 1);
    chk("R9 flag cleared", rbuf[0], 8'h00);
  endtask

  task automatic t_abort();
    logic ack;
    bstart();
    byte_out({ADDR, 1'b0}, ack);
    byte_out(8'h02, ack);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bstop();
    chk("R11 stop discards partial byte", ctrl_o, 8'hA5);
    bstart();
    byte_out({ADDR, 1'b0}, ack);
    byte_out(8'h02, ack);
    for (int i = 0; i < 3; i++) bit_out(1'b0);
    bstart();
    byte_out({ADDR, 1'b0}, ack); chk("R11 address after restart", ack, 1);
    byte_out(8'h02, ack);
    byte_out(8'h3C, ack);
    bstop();
    chk("R11 write after restart", ctrl_o, 8'h3C);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_ctrl();
    t_foreign();
    t_mem();
    t_ro();
    t_irq();
    t_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule